// File: doc/BRIEF.md
# On-Screen Display Control Registers with Page-Memory Clear

This block holds the control state of an on-screen display engine. A simple host port sits in front of it in place of a serial-bus slave: one address bus, a write strobe, a read strobe and byte-wide data. The port reaches three control bytes and a 512-entry display page memory. Each page entry carries two 8-bit planes, a character code and an attribute code.

The block decodes the control bytes into signals for the video pipeline: a master display enable, two window enables that the master enable gates, a transparency-disable flag, a font bit-plane select, the number of pixels per line and the blink period in vertical fields. A clear command in the first control byte starts a sequencer. The sequencer writes zero to both planes of every page entry, one entry per clock. The command bit drops back to 0 by itself when the sweep ends. Page readback returns either the character plane or the attribute plane, as one bit of the font-access byte selects.

Address map: host_addr[10]=0 selects a control byte by host_addr[1:0] (0 frame control A, 1 frame control B, 2 font access, 3 reads zero). host_addr[10]=1 selects the page memory. host_addr[9] picks the plane a write goes to (0 character, 1 attribute), and host_addr[8:0] is the entry index.

Top module: `osd_ctrl_top`

## Requirements
- R1: Frame control A layout: bit 0 master enable, bit 1 window 1 enable, bit 2 window 2 enable, bit 3 clear command, bit 4 transparency disable (driven on transp_dis). Bits 7:5 read back 0 whatever was written.
- R2: win1_en is 1 only when the master bit and bit 1 are both 1. win2_en is 1 only when the master bit and bit 2 are both 1.
- R3: Writing frame control A with bit 3 set starts a sweep that zeroes both planes of all 512 entries, from entry 0 up to entry 511, one entry per clock. The sweep lasts 512 cycles, after which bit 3 reads 0 again.
- R4: pix_per_line equals 512 + 64 × frame control B bits 7:5, so it runs from 512 to 960.
- R5: blink_fields equals 8 × frame control B bits 4:0. Frame control B reads back exactly as written.
- R6: With font-access bit 1 = 0, page reads return the character plane. With it = 1, they return the attribute plane.
- R7: Host writes to the page memory are ignored while a sweep is running.
- R8: A read of frame control A during a sweep returns bit 3 = 1.
- R9: After reset every control byte reads 0, and pix_per_line is 512. Font-access bits 7:2 read 0. Bit 0 drives font_bit_sel.
- R10: A read issued with host_rd at one clock edge appears on rd_data after that edge and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_addr | input | 11 | Register or page-memory address |
| host_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| osd_en | output | 1 | Master display enable |
| win1_en | output | 1 | Gated window 1 enable |
| win2_en | output | 1 | Gated window 2 enable |
| transp_dis | output | 1 | Transparency disable |
| font_bit_sel | output | 1 | Font pixel bit-plane select |
| pix_per_line | output | 10 | Pixels per line |
| blink_fields | output | 8 | Blink period in vertical fields |

## Verification
The sweep is the hard part to observe: it is internal, and the host port only sees it through the self-clearing command bit. The bench first writes nonzero values into both planes of entries 0, 1, 256 and 511. It then starts the sweep and tries a page write in the very next cycle, which must be lost. After that it reads frame control A on every clock until the command bit falls, and counts the reads to confirm the sweep length. Reading the seeded entries back at the end shows that the first and the last index were both cleared, and so was the entry written during the sweep.

// File: rtl/osd_regs_pkg.sv
package osd_regs_pkg;
    localparam int BYTE_W    = 8;
    localparam int RAM_DEPTH = 512;
    localparam int IDX_W     = $clog2(RAM_DEPTH);
    localparam int HADDR_W   = IDX_W + 2;
    localparam int PPL_W     = 10;
    localparam int BLINK_W   = 8;
    localparam int PPL_BASE  = 512;
    localparam int PPL_STEP  = 64;

    typedef enum logic [1:0] {
        REG_FRAME_A = 2'd0,
        REG_FRAME_B = 2'd1,
        REG_FONT    = 2'd2,
        REG_NONE    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic transp_dis;
        logic win2;
        logic win1;
        logic master;
    } frame_a_t;

    typedef struct packed {
        logic [2:0] ppl_code;
        logic [4:0] blink;
    } frame_b_t;

    typedef struct packed {
        logic attr_sel;
        logic font_bit;
    } font_t;

    function automatic logic [PPL_W-1:0] ppl_decode(input logic [2:0] code);
        return PPL_W'(PPL_BASE) + PPL_W'(PPL_STEP) * PPL_W'(code);
    endfunction

    function automatic logic [BLINK_W-1:0] blink_decode(input logic [4:0] val);
        return {val, 3'b000};
    endfunction

    function automatic logic [BYTE_W-1:0] pack_frame_a(input frame_a_t f, input logic busy);
        return {3'b000, f.transp_dis, busy, f.win2, f.win1, f.master};
    endfunction
endpackage

// File: rtl/osd_ctrl_regs.sv
module osd_ctrl_regs
    import osd_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              clr_busy,
    output frame_a_t          frame_a,
    output frame_b_t          frame_b,
    output font_t             font,
    output logic              clr_start,
    output logic [BYTE_W-1:0] rd_byte
);
    assign clr_start = wr_en && (sel == REG_FRAME_A) && wdata[3] && !clr_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_a <= '0;
            frame_b <= '0;
            font    <= '0;
        end else if (wr_en) begin
            case (sel)
                REG_FRAME_A: frame_a <= '{transp_dis: wdata[4], win2: wdata[2],
                                          win1: wdata[1], master: wdata[0]};
                REG_FRAME_B: frame_b <= wdata;
                REG_FONT:    font    <= wdata[1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            REG_FRAME_A: rd_byte = pack_frame_a(frame_a, clr_busy);
            REG_FRAME_B: rd_byte = frame_b;
            REG_FONT:    rd_byte = {6'b0, font};
            default:     rd_byte = '0;
        endcase
    end

    // R3
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        clr_busy |-> !clr_start);
endmodule

// File: rtl/osd_page_clear.sv
module osd_page_clear
    import osd_regs_pkg::*;
#(
    parameter int DEPTH = RAM_DEPTH,
    localparam int IW   = $clog2(DEPTH)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy) begin
            if (idx == LAST) busy <= 1'b0;
            else             idx  <= idx + IW'(1);
        end
    end

    // R3
    sweep_end_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && idx == LAST) |=> !busy);
    // R3
    sweep_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(rst)) |-> (idx == $past(idx) + IW'(1)));
    // R3
    sweep_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (idx == '0));
endmodule

// File: rtl/osd_page_ram.sv
module osd_page_ram
    import osd_regs_pkg::*;
#(
    parameter int DEPTH = RAM_DEPTH,
    parameter int DW    = BYTE_W,
    localparam int IW   = $clog2(DEPTH)
)(
    input  logic          clk,
    input  logic          host_we,
    input  logic          host_plane,
    input  logic [IW-1:0] host_idx,
    input  logic [DW-1:0] host_data,
    input  logic          clr_we,
    input  logic [IW-1:0] clr_idx,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] char_q,
    output logic [DW-1:0] attr_q
);
    logic [DW-1:0] char_mem [DEPTH];
    logic [DW-1:0] attr_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (clr_we) begin
            char_mem[clr_idx] <= '0;
            attr_mem[clr_idx] <= '0;
        end else if (host_we) begin
            if (host_plane) attr_mem[host_idx] <= host_data;
            else            char_mem[host_idx] <= host_data;
        end
    end

    assign char_q = char_mem[rd_idx];
    assign attr_q = attr_mem[rd_idx];
endmodule

// File: rtl/osd_ctrl_top.sv
module osd_ctrl_top
    import osd_regs_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0]  host_wdata,
    output logic [BYTE_W-1:0]  rd_data,
    output logic               osd_en,
    output logic               win1_en,
    output logic               win2_en,
    output logic               transp_dis,
    output logic               font_bit_sel,
    output logic [PPL_W-1:0]   pix_per_line,
    output logic [BLINK_W-1:0] blink_fields
);
    logic             is_ram;
    logic             plane;
    logic [IDX_W-1:0] idx;
    reg_sel_e         sel;
    frame_a_t         frame_a;
    frame_b_t         frame_b;
    font_t            font;
    logic             clr_start;
    logic             clr_busy;
    logic [IDX_W-1:0] clr_idx;
    logic [BYTE_W-1:0] reg_rd;
    logic [BYTE_W-1:0] char_q;
    logic [BYTE_W-1:0] attr_q;

    assign is_ram = host_addr[HADDR_W-1];
    assign plane  = host_addr[IDX_W];
    assign idx    = host_addr[IDX_W-1:0];
    assign sel    = reg_sel_e'(host_addr[1:0]);

    osd_ctrl_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (host_wr && !is_ram),
        .sel      (sel),
        .wdata    (host_wdata),
        .clr_busy (clr_busy),
        .frame_a  (frame_a),
        .frame_b  (frame_b),
        .font     (font),
        .clr_start(clr_start),
        .rd_byte  (reg_rd)
    );

    osd_page_clear #(.DEPTH(RAM_DEPTH)) u_clear (
        .clk  (clk),
        .rst  (rst),
        .start(clr_start),
        .busy (clr_busy),
        .idx  (clr_idx)
    );

    osd_page_ram #(.DEPTH(RAM_DEPTH), .DW(BYTE_W)) u_ram (
        .clk       (clk),
        .host_we   (host_wr && is_ram && !clr_busy),
        .host_plane(plane),
        .host_idx  (idx),
        .host_data (host_wdata),
        .clr_we    (clr_busy),
        .clr_idx   (clr_idx),
        .rd_idx    (idx),
        .char_q    (char_q),
        .attr_q    (attr_q)
    );

    always_ff @(posedge clk) begin
        if (rst)          rd_data <= '0;
        else if (host_rd) rd_data <= is_ram ? (font.attr_sel ? attr_q : char_q) : reg_rd;
    end

    assign osd_en       = frame_a.master;
    assign win1_en      = frame_a.master & frame_a.win1;
    assign win2_en      = frame_a.master & frame_a.win2;
    assign transp_dis   = frame_a.transp_dis;
    assign font_bit_sel = font.font_bit;
    assign pix_per_line = ppl_decode(frame_b.ppl_code);
    assign blink_fields = blink_decode(frame_b.blink);

    // R2
    win_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (win1_en || win2_en) |-> osd_en);
    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !is_ram && sel == REG_FRAME_A) |=> (rd_data[7:5] == 3'b000));
    // R8
    busy_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !is_ram && sel == REG_FRAME_A && clr_busy) |=> rd_data[3]);
    // R4
    ppl_range_chk: assert property (@(posedge clk) disable iff (rst)
        (pix_per_line >= PPL_W'(PPL_BASE)) && (pix_per_line[5:0] == 6'd0));
    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> $stable(rd_data));
endmodule

// File: tb/sim_osd_ctrl_top.sv
module sim_osd_ctrl_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [10:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  rd_data;
    logic        osd_en, win1_en, win2_en, transp_dis, font_bit_sel;
    logic [9:0]  pix_per_line;
    logic [7:0]  blink_fields;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    osd_ctrl_top u0 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .rd_data(rd_data),
        .osd_en(osd_en), .win1_en(win1_en), .win2_en(win2_en),
        .transp_dis(transp_dis), .font_bit_sel(font_bit_sel),
        .pix_per_line(pix_per_line), .blink_fields(blink_fields)
    );

    localparam logic [10:0] A_FA = 11'd0, A_FB = 11'd1, A_FONT = 11'd2, A_NONE = 11'd3;

    function automatic logic [10:0] ram_a(input logic pl, input int i);
        return {1'b1, pl, 9'(i)};
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(posedge clk);
        #1;
        d = rd_data;
        host_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(A_FA, d);   chk("R9 frameA reset", d, 0);
        rd(A_FB, d);   chk("R9 frameB reset", d, 0);
        rd(A_FONT, d); chk("R9 font reset", d, 0);
        chk("R9 ppl reset", pix_per_line, 512);
        chk("R2 win reset", {osd_en, win1_en, win2_en}, 0);
    endtask

    task automatic t_frame_a();
        logic [7:0] d;
        wr(A_FA, 8'hF7);
        rd(A_FA, d); chk("R1 reserved bits", d, 8'h17);
        chk("R1 transp_dis", transp_dis, 1);
        chk("R2 both windows", {osd_en, win1_en, win2_en}, 3'b111);
        wr(A_FA, 8'h06);
        chk("R2 master off", {osd_en, win1_en, win2_en}, 3'b000);
        wr(A_FA, 8'h03);
        chk("R2 win1 only", {osd_en, win1_en, win2_en}, 3'b110);
        wr(A_FA, 8'h05);
        chk("R2 win2 only", {osd_en, win1_en, win2_en}, 3'b101);
        rd(A_NONE, d); chk("R9 unused slot", d, 0);
        #1; chk("R10 rd_data holds", rd_data, 0);
    endtask

    task automatic t_frame_b();
        logic [7:0] d;
        for (int c = 0; c < 8; c++) begin
            wr(A_FB, 8'((c << 5) | ((c * 5 + 3) & 31)));
            chk("R4 pixels per line", pix_per_line, 512 + 64 * c);
            chk("R5 blink fields", blink_fields, 8 * ((c * 5 + 3) & 31));
            rd(A_FB, d); chk("R5 readback", d, (c << 5) | ((c * 5 + 3) & 31));
        end
        wr(A_FB, 8'h1F);
        chk("R5 blink max", blink_fields, 248);
    endtask

    task automatic t_font();
        logic [7:0] d;
        wr(A_FONT, 8'hFD);
        rd(A_FONT, d); chk("R9 font reserved", d, 8'h01);
        chk("R9 font_bit_sel", font_bit_sel, 1);
        wr(A_FONT, 8'h02);
        chk("R9 font_bit_sel low", font_bit_sel, 0);
    endtask

    task automatic t_planes();
        logic [7:0] d;
        wr(ram_a(0, 5), 8'hA5);   wr(ram_a(1, 5), 8'h3C);
        wr(ram_a(0, 511), 8'h81); wr(ram_a(1, 511), 8'h7E);
        wr(A_FONT, 8'h00);
        rd(ram_a(0, 5), d);   chk("R6 char plane", d, 8'hA5);
        rd(ram_a(1, 511), d); chk("R6 char plane top", d, 8'h81);
        wr(A_FONT, 8'h02);
        rd(ram_a(0, 5), d);   chk("R6 attr plane", d, 8'h3C);
        rd(ram_a(0, 511), d); chk("R6 attr plane top", d, 8'h7E);
    endtask

    task automatic t_clear();
        logic [7:0] d;
        int n;
        int idxs[4] = '{0, 1, 256, 511};
        foreach (idxs[k]) begin
            wr(ram_a(0, idxs[k]), 8'(8'h11 + k));
            wr(ram_a(1, idxs[k]), 8'(8'hE0 + k));
        end
        wr(A_FA, 8'h09);
        wr(ram_a(0, 0), 8'h77);
        n = 0;
        rd(A_FA, d); n++;
        chk("R8 busy flag reads 1", d, 8'h09);
        while (d[3] && n < 2000) begin
            rd(A_FA, d); n++;
        end
        chk("R3 sweep length", (n >= 508 && n <= 512) ? 1 : 0, 1);
        chk("R3 bit self-clears", d, 8'h01);
        wr(A_FONT, 8'h00);
        foreach (idxs[k]) begin
            rd(ram_a(0, idxs[k]), d); chk("R3 char cleared", d, 0);
        end
        rd(ram_a(0, 5), d); chk("R3 char mid cleared", d, 0);
        wr(A_FONT, 8'h02);
        foreach (idxs[k]) begin
            rd(ram_a(0, idxs[k]), d); chk("R3 attr cleared", d, 0);
        end
        wr(A_FONT, 8'h00);
        rd(ram_a(0, 0), d); chk("R7 write during sweep ignored", d, 0);
        wr(ram_a(0, 0), 8'h5A);
        rd(ram_a(0, 0), d); chk("R7 write after sweep lands", d, 8'h5A);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_frame_a();
        t_frame_b();
        t_font();
        t_planes();
        t_clear();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule